// File: doc/BRIEF.md
# Two-Wire Serial Slave for a Dual Wiper Register Pair

This block is a synchronous slave on a two-wire serial bus (clock line and open-drain data line). It puts two 8-bit wiper position registers behind that bus. Each register selects one of 256 positions. The bus lines are sampled with the system clock, which must run at least eight times faster than the serial clock. The block recognises bus start, repeated start and stop conditions. It drives the data line only through an output enable that pulls the line low.

After a start condition the first byte is a control byte, sent most significant bit first:

- The upper four bits must equal the type code 0101.
- The next three bits must equal the live select inputs.
- The lowest bit chooses the direction.

On a match the block acknowledges. It then either stores incoming bytes into the wipers or sends the wiper values back. In both cases the wipers are visited in a cyclic order that starts again at wiper 0 after every accepted control byte.

Top module: `twowire_wiper_slave`

## Requirements
- R1: After reset the data-line output enable is deasserted and both wipers hold the reset position 0x80.
- R2: A start or repeated start always begins reception of a new control byte. A stop at any point releases the data line and discards a partly received byte.
- R3: A control byte whose bits 7..4 are 0101 and whose bits 3..1 equal the select inputs, as sampled when its eighth bit is clocked in, is acknowledged. The data line is held low for the whole high phase of the ninth clock. Select changes at other times have no effect.
- R4: A control byte that does not match gets no acknowledge. The slave then leaves the data line released and the wipers untouched until the next start.
- R5: When bit 0 of the control byte is 0 (write), every data byte is acknowledged. Data bytes go to wiper 0, then wiper 1, then wiper 0 again, and so on without limit.
- R6: When bit 0 of the control byte is 1 (read), the slave sends wiper 0, then wiper 1, cyclically, most significant bit first. Each following byte is sent only while the master acknowledges.
- R7: After the master answers a read byte with not-acknowledge (data line high on the ninth clock), the slave keeps the data line released until the next start or stop.
- R8: The output enable changes only while the synchronised clock line is low.
- R9: The wipers change only when a complete write data byte has been received under a matching control byte.
- R10: The behaviour above holds at a serial clock period of only eight system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus (wired-AND of all drivers) |
| sel_i | input | SEL_W (3) | Pin-strapped select bits compared with control byte bits 3..1 |
| sda_oe_o | output | 1 | High pulls the data line low, low releases it |
| wipers_o | output | NUM_WIPERS*DATA_W (16) | Wiper positions; wiper 0 in bits 7..0, wiper 1 in bits 15..8 |

## Verification
The hardest situation to reach is a select-input change racing the control byte. The comparison must use the select value present when the eighth bit arrives, not the value present at start. The stimulus changes the select inputs after the first address bit, then sends the new address. It changes them again in the middle of a data byte. Other hard cases follow the same approach: a stop in the middle of a data byte, and further clocking after a master not-acknowledge. Each one is followed by continuous comparison of the wipers against a behavioural model and by a read-back. Together these show that no stray write or drive took place.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AWAIT,
      ST_AACK,
      ST_WDATA,
      ST_WWAIT,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_RNEXT,
      ST_IGNORE
   } tw_state_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] sync_o,
   output logic [LINES-1:0] rise_o,
   output logic [LINES-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_line_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe <= '1;
            last <= 1'b1;
         end else begin
            pipe <= {pipe[STAGES-2:0], raw_i[g]};
            last <= pipe[STAGES-1];
         end
      end
      assign sync_o[g] = pipe[STAGES-1];
      assign rise_o[g] = pipe[STAGES-1] & ~last;
      assign fall_o[g] = ~pipe[STAGES-1] & last;
   end
endmodule

// File: rtl/tw_wiper_bank.sv
module tw_wiper_bank #(
   parameter int              DATA_W    = 8,
   parameter int              NUM       = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h80,
   localparam int             IDX_W     = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NUM*DATA_W-1:0] wipers_o
);
   logic [NUM-1:0] we;

   for (genvar g = 0; g < NUM; g++) begin : g_wiper
      logic [DATA_W-1:0] pos;
      assign we[g] = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pos <= RESET_VAL;
         else if (we[g]) pos <= wr_data;
      end
      assign wipers_o[g*DATA_W +: DATA_W] = pos;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = wipers_o[i*DATA_W +: DATA_W];
      end
   end

   assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));
   assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wipers_o));
endmodule

// File: rtl/tw_protocol.sv
module tw_protocol
   import tw_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter int              SEL_W     = 3,
   parameter int              NUM       = 2,
   parameter logic [3:0]      TYPE_CODE = 4'b0101,
   localparam int             IDX_W     = (NUM > 1) ? $clog2(NUM) : 1,
   localparam int             CNT_W     = $clog2(DATA_W),
   localparam int             TYPE_W    = DATA_W - 1 - SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              scl_rise,
   input  logic              sda_s,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              sda_oe_o,
   input  logic              scl_fall
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (TYPE_W != 4) begin : g_bad_layout
      $error("tw_protocol: control byte must hold 4 type bits, select bits and a direction bit");
   end

   tw_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic              rw;
   logic              oe;
   logic [DATA_W-1:0] byte_in;
   logic              start_det, stop_det, addr_hit;
   logic [IDX_W-1:0]  idx_next;

   assign start_det = scl_s && !scl_rise && sda_fall;
   assign stop_det  = scl_s && !scl_rise && sda_rise;
   assign byte_in   = {shreg[DATA_W-2:0], sda_s};
   assign addr_hit  = (byte_in[DATA_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0])
                   && (byte_in[SEL_W:1] == sel_i);
   assign idx_next  = (idx == IDX_W'(NUM - 1)) ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         idx     <= '0;
         rw      <= 1'b0;
         oe      <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
            oe    <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            cnt   <= '0;
            oe    <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: if (scl_rise) begin
                  shreg <= byte_in;
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (addr_hit) begin
                        rw    <= byte_in[0];
                        state <= ST_AWAIT;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_AWAIT: if (scl_fall) begin
                  oe    <= 1'b1;
                  idx   <= '0;
                  state <= ST_AACK;
               end
               ST_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     shreg <= rd_data;
                     oe    <= ~rd_data[DATA_W-1];
                     state <= ST_RDATA;
                  end else begin
                     oe    <= 1'b0;
                     state <= ST_WDATA;
                  end
               end
               ST_WDATA: if (scl_rise) begin
                  shreg <= byte_in;
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     wr_en   <= 1'b1;
                     wr_idx  <= idx;
                     wr_data <= byte_in;
                     idx     <= idx_next;
                     state   <= ST_WWAIT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WWAIT: if (scl_fall) begin
                  oe    <= 1'b1;
                  state <= ST_WACK;
               end
               ST_WACK: if (scl_fall) begin
                  oe    <= 1'b0;
                  state <= ST_WDATA;
               end
               ST_RDATA: if (scl_fall) begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     oe    <= 1'b0;
                     state <= ST_RACK;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     shreg <= {shreg[DATA_W-2:0], 1'b0};
                     oe    <= ~shreg[DATA_W-2];
                  end
               end
               ST_RACK: if (scl_rise) begin
                  idx   <= idx_next;
                  state <= sda_s ? ST_IGNORE : ST_RNEXT;
               end
               ST_RNEXT: if (scl_fall) begin
                  shreg <= rd_data;
                  oe    <= ~rd_data[DATA_W-1];
                  state <= ST_RDATA;
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_idx   = idx;
   assign sda_oe_o = oe;

   assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && cnt == '0));
   assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe_o));
   assert_ack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK || state == ST_WACK) |-> sda_oe_o);
   assert_silent_unaddressed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe_o);
   assert_write_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(state == ST_WDATA));
endmodule

// File: rtl/twowire_wiper_slave.sv
module twowire_wiper_slave #(
   parameter int                DATA_W      = 8,
   parameter int                SEL_W       = 3,
   parameter int                NUM_WIPERS  = 2,
   parameter int                SYNC_STAGES = 2,
   parameter logic [3:0]        TYPE_CODE   = 4'b0101,
   parameter logic [DATA_W-1:0] RESET_POS   = 8'h80,
   localparam int               IDX_W       = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   input  logic [SEL_W-1:0]             sel_i,
   output logic                         sda_oe_o,
   output logic [NUM_WIPERS*DATA_W-1:0] wipers_o
);
   if (NUM_WIPERS < 2) begin : g_bad_count
      $error("twowire_wiper_slave: NUM_WIPERS must be at least 2");
   end

   logic [1:0]        ln_sync, ln_rise, ln_fall;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_data;

   tw_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({sda_i, scl_i}),
      .sync_o (ln_sync),
      .rise_o (ln_rise),
      .fall_o (ln_fall)
   );

   tw_protocol #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM(NUM_WIPERS), .TYPE_CODE(TYPE_CODE)
   ) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (ln_sync[0]),
      .scl_rise (ln_rise[0]),
      .sda_s    (ln_sync[1]),
      .sda_rise (ln_rise[1]),
      .sda_fall (ln_fall[1]),
      .sel_i    (sel_i),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .sda_oe_o (sda_oe_o),
      .scl_fall (ln_fall[0])
   );

   tw_wiper_bank #(.DATA_W(DATA_W), .NUM(NUM_WIPERS), .RESET_VAL(RESET_POS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .wipers_o (wipers_o)
   );

   assert_drive_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !$past(ln_sync[0]));
endmodule

// File: tb/sim_twowire_wiper_slave.sv
module sim_twowire_wiper_slave;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [2:0]  sel = 3'b011;
   logic        oe;
   logic [15:0] wipers;
   logic        sda_bus;

   int nchk = 0;
   int nerr = 0;
   int q = 10;
   bit settle = 1'b1;
   bit done = 1'b0;
   int mdl [2];
   int midx = 0;

   assign sda_bus = m_sda & ~oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   twowire_wiper_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sel_i(sel), .sda_oe_o(oe), .wipers_o(wipers)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every clock: wipers against the behavioural model (R9 / R4)
   always @(negedge clk) begin
      if (rst_n && !settle && !done) begin
         chk("R9 wiper model", int'(wipers), (mdl[1] << 8) | mdl[0]);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(q);
      m_scl = 1'b1; tick(q);
      m_sda = 1'b0; tick(q);
      m_scl = 1'b0; tick(q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(q);
      m_scl = 1'b1; tick(q);
      m_sda = 1'b1; tick(2*q);
   endtask

   task automatic clk_bit(input logic b, output logic seen);
      m_sda = b; tick(q);
      m_scl = 1'b1; tick(q);
      seen = sda_bus; tick(q);
      m_scl = 1'b0; tick(q);
   endtask

   task automatic tx_byte(input logic [7:0] v, input bit wr_ok, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         if (i == 0 && wr_ok) settle = 1'b1;
         clk_bit(v[i], s);
      end
      clk_bit(1'b1, ack);
      if (wr_ok) begin
         mdl[midx] = int'(v);
         midx = (midx + 1) % 2;
         tick(1);
         settle = 1'b0;
      end
   endtask

   task automatic rx_byte(input bit m_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(1'b1, v[i]);
      clk_bit(m_ack ? 1'b0 : 1'b1, s);
      midx = (midx + 1) % 2;
   endtask

   initial begin
      tick(CLK_PERIOD * 20000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] d;
      mdl[0] = 'h80; mdl[1] = 'h80;
      tick(5);
      chk("R1 reset oe", int'(oe), 0);
      chk("R1 reset wipers", int'(wipers), 'h8080);
      rst_n = 1'b1;
      tick(3);
      settle = 1'b0;

      // R3/R5: write three bytes, third wraps to wiper 0
      bus_start();
      tx_byte(8'h56, 1'b0, a); chk("R3 addr ack", int'(a), 0); midx = 0;
      tx_byte(8'h3C, 1'b1, a); chk("R5 data ack w0", int'(a), 0);
      tx_byte(8'hA5, 1'b1, a); chk("R5 data ack w1", int'(a), 0);
      tx_byte(8'h11, 1'b1, a); chk("R5 data ack wrap", int'(a), 0);
      bus_stop();
      chk("R2 released after stop", int'(oe), 0);
      chk("R5 wiper pair", int'(wipers), 'hA511);

      // R6/R7: read cyclically, then NACK and keep clocking
      bus_start();
      tx_byte(8'h57, 1'b0, a); chk("R6 read addr ack", int'(a), 0); midx = 0;
      rx_byte(1'b1, d); chk("R6 read w0", int'(d), 'h11);
      rx_byte(1'b1, d); chk("R6 read w1", int'(d), 'hA5);
      rx_byte(1'b0, d); chk("R6 read wrap w0", int'(d), 'h11);
      rx_byte(1'b0, d); chk("R7 released after nack", int'(d), 'hFF);
      chk("R7 oe after nack", int'(oe), 0);
      bus_stop();

      // R4: wrong type code, then a data byte is ignored
      bus_start();
      tx_byte(8'h76, 1'b0, a); chk("R4 type mismatch nack", int'(a), 1);
      tx_byte(8'h00, 1'b0, a); chk("R4 no ack after mismatch", int'(a), 1);
      bus_stop();
      // R4: wrong select bits
      bus_start();
      tx_byte(8'h58, 1'b0, a); chk("R4 select mismatch nack", int'(a), 1);
      tx_byte(8'h00, 1'b0, a); chk("R4 ignored byte", int'(a), 1);
      bus_stop();
      chk("R4 wipers untouched", int'(wipers), 'hA511);

      // R2: repeated start restarts the index
      bus_start();
      tx_byte(8'h56, 1'b0, a); chk("R2 write addr ack", int'(a), 0); midx = 0;
      tx_byte(8'h44, 1'b1, a); chk("R2 data ack", int'(a), 0);
      bus_start();
      tx_byte(8'h57, 1'b0, a); chk("R2 repeated start ack", int'(a), 0); midx = 0;
      rx_byte(1'b0, d); chk("R2 read after restart w0", int'(d), 'h44);
      bus_stop();

      // R3: select inputs change during control byte and during data
      sel = 3'b000;
      bus_start();
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'(8'h5C >> i), a);
         if (i == 7) sel = 3'b110;
      end
      clk_bit(1'b1, a); chk("R3 select at completion ack", int'(a), 0); midx = 0;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         if (i == 0) settle = 1'b1;
         clk_bit(1'(8'h9A >> i), a);
         if (i == 4) sel = 3'b001;
      end
      clk_bit(1'b1, a); chk("R3 late select change ignored", int'(a), 0);
      mdl[0] = 'h9A; midx = 1; tick(1); settle = 1'b0;
      bus_stop();
      chk("R3 wiper0 written", int'(wipers), 'hA59A);

      // R2: stop in the middle of a data byte discards it
      sel = 3'b011;
      bus_start();
      tx_byte(8'h56, 1'b0, a); chk("R2 addr ack before abort", int'(a), 0); midx = 0;
      for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
      bus_stop();
      chk("R2 abort released", int'(oe), 0);
      chk("R2 abort no write", int'(wipers), 'hA59A);

      // R10: fast serial clock, 8 system clocks per bit
      q = 2;
      bus_start();
      tx_byte(8'h56, 1'b0, a); chk("R10 fast addr ack", int'(a), 0); midx = 0;
      tx_byte(8'h12, 1'b1, a); chk("R10 fast w0 ack", int'(a), 0);
      tx_byte(8'h34, 1'b1, a); chk("R10 fast w1 ack", int'(a), 0);
      bus_start();
      tx_byte(8'h57, 1'b0, a); chk("R10 fast read ack", int'(a), 0); midx = 0;
      rx_byte(1'b1, d); chk("R10 fast read w0", int'(d), 'h12);
      rx_byte(1'b0, d); chk("R10 fast read w1", int'(d), 'h34);
      bus_stop();
      chk("R10 fast oe released", int'(oe), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule